// File: doc/BRIEF.md
# Register-Programmed SPI Flash Command Engine

This block is an SPI master that lets software talk to a serial NOR flash through three 32-bit registers. Software first loads a command word and a data word. The command word holds an opcode byte and a 24-bit flash address. Software then writes the control word with the outgoing byte count, the response byte count, a clock selection and a start bit. The engine opens one chip-select frame and shifts a single byte stream out, MSB first. The stream holds the opcode, then the address bytes, then up to four payload bytes from the data word. It then clocks in the requested number of response bytes and drops them into the data word.

Software polls the busy flag in the control word before each new command. While busy is set, every register write is ignored. The SPI side runs in mode 0: the clock idles low, the master changes its output on falling edges, and the flash is sampled on rising edges. The serial clock is the system clock divided by 2, 4, 8 or 16.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, spi_cs_n is 1, spi_sclk is 0 and spi_mosi is 0. All three registers read 0.
- R2: Word index 0 is the control register. It holds the send count in bits [3:0], the receive count in [7:4], a 2-bit size field in [18:17] and a 2-bit clock select in [25:24]. Busy reads in bit 16, and the start bit (bit 8) always reads 0. Word index 1 is the command word and word index 2 is the data word; both read back as written. Word index 3 reads 0.
- R3: A control write with bit 8 set, while not busy, starts a transaction if the send count is non-zero. Busy reads 1 from the next cycle and stays 1 until the frame has closed and the data word is updated. It then reads 0.
- R4: The byte stream is, in order: command[7:0], command[31:24], command[23:16], command[15:8], data[7:0], data[15:8], data[23:16], data[31:24]. Only the first send-count bytes are sent, each MSB first. spi_mosi is 0 during the receive bytes.
- R5: The k-th received byte (k counted from 0) lands in data bits [8k+7:8k], and the bits above the received bytes read 0. With a receive count of 0 the data word keeps its value.
- R6: Mode 0 framing applies. spi_sclk is low whenever spi_cs_n is high. spi_cs_n falls at least one half SCLK period before the first rising edge. Exactly 8 x (send + receive) rising edges occur per frame, and spi_cs_n returns high afterwards.
- R7: Clock select values 0, 1, 2 and 3 give an SCLK period of 2, 4, 8 and 16 system clocks.
- R8: While busy, writes to any register are ignored, including a new start.
- R9: A start with a send count of 0 is ignored: no frame opens and busy stays 0.
- R10: A send count above 8 acts as 8, and a receive count above 4 acts as 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_widx | input | 2 | Register word index (0 control, 1 command, 2 data) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_widx (combinational) |
| spi_sclk | output | 1 | SPI serial clock |
| spi_mosi | output | 1 | SPI data to flash |
| spi_cs_n | output | 1 | SPI chip select, active low |
| spi_miso | input | 1 | SPI data from flash |

## Verification
Several properties are checked on every cycle by the assertions. An accepted start must turn the sequencer active on the next cycle. SCLK must stay low outside a frame and may move only on a divider tick. MOSI must be stable across every rising edge. Register contents must not change when written while busy. The bench scenarios against a bit-level responder cover the rest: the byte order of the outgoing stream, the placement of response bytes, the measured SCLK period for each select value, and the counts of edges and lead time per frame. They also cover the clamping of oversized counts and the ignored starts, which the assertions do not check.

// File: rtl/spi_cmd_pkg.sv
`timescale 1ns/1ps
package spi_cmd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_LEAD  = 2'd1,
      ST_SHIFT = 2'd2,
      ST_TRAIL = 2'd3
   } seq_state_t;

   localparam int TX_MAX_BYTES = 8;
   localparam int RX_MAX_BYTES = 4;
   localparam int STREAM_W     = TX_MAX_BYTES * 8;
   localparam int RXWORD_W     = RX_MAX_BYTES * 8;

   localparam logic [1:0] IDX_CTRL = 2'd0;
   localparam logic [1:0] IDX_CMD  = 2'd1;
   localparam logic [1:0] IDX_DATA = 2'd2;

   localparam int BIT_START = 8;
   localparam int BIT_BUSY  = 16;
   localparam int POS_SIZE  = 17;
   localparam int POS_CSEL  = 24;
endpackage

// File: rtl/spi_clk_div.sv
`timescale 1ns/1ps
module spi_clk_div #(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en,
   input  logic [SEL_W-1:0] sel,
   output logic             tick
);
   localparam int HALF_MAX = 1 << ((1 << SEL_W) - 1);
   localparam int CNT_W    = (HALF_MAX > 2) ? $clog2(HALF_MAX) : 1;

   initial begin
      assert (SEL_W >= 1 && SEL_W <= 2)
         else $error("spi_clk_div: SEL_W must be 1 or 2");
   end

   logic [CNT_W-1:0] cnt;
   logic [CNT_W-1:0] limit;

   assign limit = CNT_W'((1 << sel) - 1);
   assign tick  = en && (cnt == limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       cnt <= '0;
      else if (!en)     cnt <= '0;
      else if (tick)    cnt <= '0;
      else              cnt <= cnt + 1'b1;
   end
endmodule

// File: rtl/spi_cmd_regs.sv
`timescale 1ns/1ps
module spi_cmd_regs
   import spi_cmd_pkg::*;
#(
   parameter int SEL_W = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [1:0]       reg_widx,
   input  logic             reg_wr,
   input  logic [31:0]      reg_wdata,
   output logic [31:0]      reg_rdata,
   input  logic             seq_active,
   input  logic             seq_done,
   input  logic [31:0]      seq_rx_word,
   output logic             go,
   output logic [3:0]       tx_eff,
   output logic [2:0]       rx_eff,
   output logic [SEL_W-1:0] csel,
   output logic [31:0]      cmd_q,
   output logic [31:0]      data_q
);
   logic [3:0] tx_q, rx_q;
   logic [1:0] size_q;
   logic       busy, wr_ok, accept;

   assign busy   = go | seq_active | seq_done;
   assign wr_ok  = reg_wr && !busy;
   assign accept = wr_ok && (reg_widx == IDX_CTRL) && reg_wdata[BIT_START]
                   && (reg_wdata[3:0] != 4'd0);

   // R10: oversized counts saturate
   assign tx_eff = (tx_q > 4'd8) ? 4'd8 : tx_q;
   assign rx_eff = (rx_q > 4'd4) ? 3'd4 : rx_q[2:0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q   <= '0;
         rx_q   <= '0;
         size_q <= '0;
         csel   <= '0;
         cmd_q  <= '0;
         data_q <= '0;
         go     <= 1'b0;
      end else begin
         go <= accept;
         if (seq_done && rx_eff != 3'd0)
            data_q <= seq_rx_word;
         if (wr_ok) begin
            case (reg_widx)
               IDX_CTRL: begin
                  tx_q   <= reg_wdata[3:0];
                  rx_q   <= reg_wdata[7:4];
                  size_q <= reg_wdata[POS_SIZE +: 2];
                  csel   <= reg_wdata[POS_CSEL +: SEL_W];
               end
               IDX_CMD:  cmd_q  <= reg_wdata;
               IDX_DATA: data_q <= reg_wdata;
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      reg_rdata = '0;
      case (reg_widx)
         IDX_CTRL: begin
            reg_rdata[3:0]              = tx_q;
            reg_rdata[7:4]              = rx_q;
            reg_rdata[BIT_BUSY]         = busy;
            reg_rdata[POS_SIZE +: 2]    = size_q;
            reg_rdata[POS_CSEL +: SEL_W] = csel;
         end
         IDX_CMD:  reg_rdata = cmd_q;
         IDX_DATA: reg_rdata = data_q;
         default:  reg_rdata = '0;
      endcase
   end

   // R8: a write during a transaction leaves the registers untouched
   p_busy_wr_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (reg_wr && busy && !seq_done) |=> ($stable(cmd_q) && $stable(data_q)));
endmodule

// File: rtl/spi_cmd_seq.sv
`timescale 1ns/1ps
module spi_cmd_seq
   import spi_cmd_pkg::*;
(
   input  logic        clk,
   input  logic        rst_n,
   input  logic        go,
   input  logic        tick,
   input  logic [3:0]  tx_bytes,
   input  logic [2:0]  rx_bytes,
   input  logic [31:0] cmd_q,
   input  logic [31:0] data_q,
   input  logic        miso,
   output logic        sclk,
   output logic        mosi,
   output logic        cs_n,
   output logic        active,
   output logic        done,
   output logic [31:0] rx_word
);
   localparam int BIT_W = $clog2((TX_MAX_BYTES + RX_MAX_BYTES) * 8 + 1);

   seq_state_t           state;
   logic [STREAM_W-1:0]  tx_sr, stream, keep;
   logic [BIT_W-1:0]     bitcnt, total_bits, tx_bits;
   logic [BIT_W-1:0]     new_tx_bits, new_total;
   logic [3:0]           byte_sum;
   logic [4:0]           rxi;

   assign stream = {cmd_q[7:0], cmd_q[31:24], cmd_q[23:16], cmd_q[15:8],
                    data_q[7:0], data_q[15:8], data_q[23:16], data_q[31:24]};
   assign byte_sum    = tx_bytes + {1'b0, rx_bytes};
   assign new_tx_bits = BIT_W'({tx_bytes, 3'b000});
   assign new_total   = BIT_W'({byte_sum, 3'b000});
   assign keep        = ~({STREAM_W{1'b1}} >> new_tx_bits);

   assign cs_n   = (state == ST_IDLE);
   assign active = (state != ST_IDLE);
   assign mosi   = tx_sr[STREAM_W-1];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         tx_sr      <= '0;
         bitcnt     <= '0;
         total_bits <= '0;
         tx_bits    <= '0;
         rxi        <= '0;
         rx_word    <= '0;
         sclk       <= 1'b0;
         done       <= 1'b0;
      end else begin
         done <= 1'b0;
         case (state)
            ST_IDLE: if (go) begin
               tx_sr      <= stream & keep;
               tx_bits    <= new_tx_bits;
               total_bits <= new_total;
               bitcnt     <= '0;
               rxi        <= '0;
               rx_word    <= '0;
               state      <= ST_LEAD;
            end
            ST_LEAD: if (tick) state <= ST_SHIFT;
            ST_SHIFT: if (tick) begin
               if (!sclk) begin
                  sclk <= 1'b1;
                  if (bitcnt >= tx_bits) begin
                     rx_word[{rxi[4:3], ~rxi[2:0]}] <= miso;
                     rxi <= rxi + 1'b1;
                  end
               end else begin
                  sclk   <= 1'b0;
                  tx_sr  <= tx_sr << 1;
                  bitcnt <= bitcnt + 1'b1;
                  if (bitcnt == total_bits - 1'b1) state <= ST_TRAIL;
               end
            end
            ST_TRAIL: if (tick) begin
               state <= ST_IDLE;
               done  <= 1'b1;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   // R6: clock stays low outside a frame
   p_sclk_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> !cs_n);
   // R7: clock edges only on divider ticks
   p_sclk_tick_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (state == ST_SHIFT && !tick) |=> $stable(sclk));
   // R4: data to flash is stable across each rising edge
   p_mosi_stable_r4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> $stable(mosi));
endmodule

// File: rtl/spi_cmd_engine.sv
`timescale 1ns/1ps
module spi_cmd_engine #(
   parameter int DIV_SEL_W = 2
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic [1:0]  reg_widx,
   input  logic        reg_wr,
   input  logic [31:0] reg_wdata,
   output logic [31:0] reg_rdata,
   output logic        spi_sclk,
   output logic        spi_mosi,
   output logic        spi_cs_n,
   input  logic        spi_miso
);
   initial begin
      assert (DIV_SEL_W >= 1 && DIV_SEL_W <= 2)
         else $error("spi_cmd_engine: DIV_SEL_W must fit the 2-bit select field");
   end

   logic                 go, tick, active, done;
   logic [3:0]           tx_eff;
   logic [2:0]           rx_eff;
   logic [DIV_SEL_W-1:0] csel;
   logic [31:0]          cmd_q, data_q, rx_word;

   spi_cmd_regs #(.SEL_W(DIV_SEL_W)) u_regs (
      .clk(clk), .rst_n(rst_n), .reg_widx(reg_widx), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .seq_active(active),
      .seq_done(done), .seq_rx_word(rx_word), .go(go), .tx_eff(tx_eff),
      .rx_eff(rx_eff), .csel(csel), .cmd_q(cmd_q), .data_q(data_q)
   );

   spi_clk_div #(.SEL_W(DIV_SEL_W)) u_div (
      .clk(clk), .rst_n(rst_n), .en(active), .sel(csel), .tick(tick)
   );

   spi_cmd_seq u_seq (
      .clk(clk), .rst_n(rst_n), .go(go), .tick(tick), .tx_bytes(tx_eff),
      .rx_bytes(rx_eff), .cmd_q(cmd_q), .data_q(data_q), .miso(spi_miso),
      .sclk(spi_sclk), .mosi(spi_mosi), .cs_n(spi_cs_n), .active(active),
      .done(done), .rx_word(rx_word)
   );

   // R3: an accepted start opens the frame on the next cycle
   p_go_starts_r3: assert property (@(posedge clk) disable iff (!rst_n)
      go |=> active);
endmodule

// File: tb/tb_spi_cmd_engine.sv
`timescale 1ns/1ps
module tb_spi_cmd_engine;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  reg_widx = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        spi_sclk, spi_mosi, spi_cs_n, spi_miso;

   int tests = 0;
   int fails = 0;

   spi_cmd_engine dut (
      .clk(clk), .rst_n(rst_n), .reg_widx(reg_widx), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .spi_sclk(spi_sclk),
      .spi_mosi(spi_mosi), .spi_cs_n(spi_cs_n), .spi_miso(spi_miso)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   // flash responder
   int          rcnt = 0;
   int          resp_txb = 0;
   logic [31:0] resp = '0;
   logic [95:0] cap = '0;
   time         t_csfall = 0, t_first = 0, t_period = 0;

   assign spi_miso = (rcnt >= resp_txb && rcnt < resp_txb + 32)
                     ? resp[31 - (rcnt - resp_txb)] : 1'b0;

   always @(posedge spi_sclk or negedge spi_cs_n) begin
      if (spi_sclk) begin
         cap <= {cap[94:0], spi_mosi};
         if (rcnt == 0) t_first <= $time;
         if (rcnt == 1) t_period <= $time - t_first;
         rcnt <= rcnt + 1;
      end else begin
         rcnt     <= 0;
         cap      <= '0;
         t_csfall <= $time;
      end
   end

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] idx, input logic [31:0] d);
      @(negedge clk);
      reg_widx = idx; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [1:0] idx, output logic [31:0] d);
      @(negedge clk);
      reg_widx = idx;
      #1 d = reg_rdata;
   endtask

   task automatic wait_idle();
      logic [31:0] c;
      c = 32'h1_0000;
      while (c[16]) rd(2'd0, c);
   endtask

   function automatic logic [31:0] ctl(input int tx, input int rx, input int sel, input bit st);
      return 32'(tx & 15) | (32'(rx & 15) << 4) | (32'(sel) << 24) | (st ? 32'h100 : 32'h0);
   endfunction

   function automatic logic [63:0] exp_stream(input logic [31:0] c, input logic [31:0] d, input int tx);
      logic [7:0] b [8];
      logic [63:0] e;
      b[0] = c[7:0];   b[1] = c[31:24]; b[2] = c[23:16]; b[3] = c[15:8];
      b[4] = d[7:0];   b[5] = d[15:8];  b[6] = d[23:16]; b[7] = d[31:24];
      e = '0;
      for (int k = 0; k < tx; k++) e = (e << 8) | 64'(b[k]);
      return e;
   endfunction

   // one full transaction with all frame checks
   task automatic run_case(input int tx, input int rx, input int sel, input logic [31:0] c,
                           input logic [31:0] d, input logic [31:0] r, input logic [31:0] exp_d);
      int te, re;
      logic [31:0] v;
      logic [95:0] txv, rxm;
      te = (tx > 8) ? 8 : tx;
      re = (rx > 4) ? 4 : rx;
      wr(2'd2, d);
      wr(2'd1, c);
      resp = r; resp_txb = te * 8;
      wr(2'd0, ctl(tx, rx, sel, 1'b1));
      wait_idle();
      chk("R6 edge count", 64'(rcnt), 64'((te + re) * 8));
      txv = (cap >> (re * 8)) & ((96'd1 << (te * 8)) - 96'd1);
      chk("R4 stream", txv[63:0], exp_stream(c, d, te));
      rxm = cap & ((96'd1 << (re * 8)) - 96'd1);
      chk("R4 mosi low in receive", rxm[63:0], 64'd0);
      rd(2'd2, v);
      chk("R5 data word", 64'(v), 64'(exp_d));
      chk("R7 period", 64'(t_period / CLK_PERIOD), 64'(2 << sel));
      chk("R6 cs lead", 64'((t_first - t_csfall) >= (CLK_PERIOD << sel)), 64'd1);
      chk("R6 idle lines", {62'd0, spi_cs_n, spi_sclk}, 64'd2);
   endtask

   localparam int NV = 7;
   localparam int          V_TX  [NV] = '{1, 1, 4, 4, 8, 4, 5};
   localparam int          V_RX  [NV] = '{0, 1, 1, 4, 0, 0, 2};
   localparam int          V_SEL [NV] = '{0, 1, 2, 3, 0, 1, 2};
   localparam logic [31:0] V_CMD [NV] = '{32'h0000_0006, 32'h0000_0005, 32'h0000_00AB,
                                          32'h1234_5603, 32'hABCD_EF02, 32'h0100_00D8, 32'h5566_770B};
   localparam logic [31:0] V_DAT [NV] = '{32'h1122_3344, 32'hFFFF_FFFF, 32'h0, 32'h0,
                                          32'h4433_2211, 32'hCAFE_F00D, 32'h0000_00FF};
   localparam logic [31:0] V_RSP [NV] = '{32'h0, 32'hA500_0000, 32'h1700_0000, 32'hDEAD_BEEF,
                                          32'h0, 32'h0, 32'h8001_0000};
   localparam logic [31:0] V_EXP [NV] = '{32'h1122_3344, 32'h0000_00A5, 32'h0000_0017, 32'hEFBE_ADDE,
                                          32'h4433_2211, 32'hCAFE_F00D, 32'h0000_0180};

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL R3 watchdog: actual hang expected idle");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int n;
      #(CLK_PERIOD * 3);
      chk("R1 lines", {61'd0, spi_cs_n, spi_sclk, spi_mosi}, 64'd4);
      rst_n = 1'b1;
      rd(2'd0, v); chk("R1 ctrl", 64'(v), 64'd0);
      rd(2'd1, v); chk("R1 cmd", 64'(v), 64'd0);
      rd(2'd2, v); chk("R1 data", 64'(v), 64'd0);

      // R2 field readback without start
      wr(2'd0, 32'h0104_0023 | 32'hFC00_0000);
      rd(2'd0, v); chk("R2 ctrl fields", 64'(v), 64'h0104_0023);
      chk("R2 no frame", 64'(spi_cs_n), 64'd1);
      wr(2'd1, 32'h89AB_CDEF);
      rd(2'd1, v); chk("R2 cmd readback", 64'(v), 64'h89AB_CDEF);
      rd(2'd3, v); chk("R2 unused word", 64'(v), 64'd0);

      for (int i = 0; i < NV; i++)
         run_case(V_TX[i], V_RX[i], V_SEL[i], V_CMD[i], V_DAT[i], V_RSP[i], V_EXP[i]);

      // R10 clamp: send 15 -> 8, receive 7 -> 4
      run_case(15, 7, 0, 32'h0102_039F, 32'h0A0B_0C0D, 32'h1122_3344, 32'h4433_2211);

      // R3 / R2 / R8: busy, start readback, writes ignored while busy
      wr(2'd1, 32'h0000_0003);
      resp = 32'h0; resp_txb = 32;
      wr(2'd0, ctl(4, 4, 3, 1'b1));
      rd(2'd0, v);
      chk("R3 busy set", 64'(v[16]), 64'd1);
      chk("R2 start reads zero", 64'(v[8]), 64'd0);
      wr(2'd0, ctl(1, 0, 0, 1'b1));
      wr(2'd1, 32'h5555_5555);
      wait_idle();
      chk("R8 start ignored edges", 64'(rcnt), 64'd64);
      rd(2'd1, v); chk("R8 cmd kept", 64'(v), 64'h0000_0003);
      rd(2'd0, v); chk("R8 ctrl kept", 64'(v), 64'(ctl(4, 4, 3, 1'b0)));
      chk("R3 busy clear", 64'(v[16]), 64'd0);
      repeat (40) @(negedge clk);
      chk("R8 no second frame", 64'(spi_cs_n), 64'd1);

      // R9: zero send count with start
      n = rcnt;
      wr(2'd0, ctl(0, 1, 0, 1'b1));
      rd(2'd0, v); chk("R9 busy stays clear", 64'(v[16]), 64'd0);
      repeat (20) @(negedge clk);
      chk("R9 no frame", {63'd0, spi_cs_n}, 64'd1);
      chk("R9 no edges", 64'(rcnt), 64'(n));

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule